// File: doc/BRIEF.md
# Register-Mapped Integer Divider

This block is a 32-bit integer divider that software drives through seven word registers on a simple single-cycle bus. Software places a dividend and a divisor into operand registers. Each operand sits behind two addresses that share one storage register. The address used on the most recent operand write decides whether the division treats the operands as two's-complement or as unsigned. Every operand write starts a fresh division. The quotient and remainder appear after a fixed number of cycles, and a status word reports when they are valid.

The division is iterative and resolves four quotient bits per clock. For a signed division, both operands are first turned into magnitudes, the unsigned core runs on them, and the signs are then applied to the results. Software can write the quotient and remainder registers directly, for example to restore a saved context. Such a write stops any division in progress. A DIRTY flag records that results were produced or restored and not yet fully read. Only a read of the quotient clears it, so software reads the remainder first and the quotient last.

Top module: `mmio_divider`

Register addresses on `bus_addr`: 0 unsigned dividend, 1 unsigned divisor, 2 signed dividend, 3 signed divisor, 4 quotient, 5 remainder, 6 status, 7 reserved (reads 0).

## Requirements
- R1: Addresses 0 and 2 read and write the same dividend register, and addresses 1 and 3 the same divisor register. Reading any of these four addresses returns the stored operand.
- R2: A write to any of addresses 0 to 3 starts a new division. In the following cycle READY is 0 and DIRTY is 1.
- R3: READY returns to 1 exactly 8 clock edges after the edge that took the starting write. An operand write during a division restarts this count from the new write.
- R4: An unsigned division (last operand write to address 0 or 1) gives quotient = floor(dividend / divisor) and remainder = dividend mod divisor.
- R5: A signed division (last operand write to address 2 or 3) gives a quotient truncated toward zero. The quotient is negative only when the operand signs differ, and the remainder carries the dividend's sign. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: Division by zero finishes in the normal 8 cycles with remainder = dividend. The quotient is 0xFFFFFFFF in unsigned mode. In signed mode it is -1 for a non-negative dividend and +1 for a negative one.
- R7: A write to address 4 or 5 stores the written word, stops any division in progress, and sets READY and DIRTY in the next cycle.
- R8: A read of address 4 clears DIRTY. A read of address 5 leaves DIRTY unchanged.
- R9: A read of address 6 returns READY in bit 0, DIRTY in bit 1 and zero in bits 31:2. Writes to addresses 6 and 7 change no state.
- R10: After reset READY is 1, DIRTY is 0, and the operands, quotient and remainder read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the request |

## Verification
The bench polls the status word on every cycle after a start. A divider that finished one cycle early or late, or that failed to restart on a second operand write, shows READY at the wrong poll. It covers all four sign combinations, the most negative dividend divided by -1, and division by zero in both modes. A wrong sign rule, a bad negation at the overflow case, or a hang on a zero divisor each shows up as a wrong result word. It also aliases a signed dividend with an unsigned divisor write, to catch a mode taken from the wrong write. It writes a result register in the middle of a division, to catch an abort that leaves READY low or lets the finishing division overwrite the restored value. It reads the remainder and then the quotient, to catch DIRTY being cleared by the wrong register.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        A_UNUM  = 3'd0,
        A_UDEN  = 3'd1,
        A_SNUM  = 3'd2,
        A_SDEN  = 3'd3,
        A_QUOT  = 3'd4,
        A_REM   = 3'd5,
        A_STAT  = 3'd6,
        A_RSVD  = 3'd7
    } div_addr_e;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_DIRTY_BIT = 1;
endpackage

// File: rtl/div_operand_prep.sv
`timescale 1ns/1ps
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_num_o,
    output logic [W-1:0] mag_den_o,
    output logic         neg_q_o,
    output logic         neg_r_o
);
    logic num_neg, den_neg;

    always_comb begin
        num_neg   = signed_i & num_i[W-1];
        den_neg   = signed_i & den_i[W-1];
        mag_num_o = num_neg ? (~num_i + 1'b1) : num_i;
        mag_den_o = den_neg ? (~den_i + 1'b1) : den_i;
        neg_q_o   = num_neg ^ den_neg;
        neg_r_o   = num_neg;
    end
endmodule

// File: rtl/div_radix_step.sv
`timescale 1ns/1ps
module div_radix_step #(
    parameter int W = 32,
    parameter int K = 4
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W-1:0] r_c [K+1];
    logic [W-1:0] q_c [K+1];

    assign r_c[0] = rem_i;
    assign q_c[0] = quo_i;

    for (genvar i = 0; i < K; i++) begin : g_bit
        logic [W:0] trial;
        logic [W:0] diff;
        logic       fits;
        assign trial    = {r_c[i], q_c[i][W-1]};
        assign diff     = trial - {1'b0, den_i};
        assign fits     = (trial >= {1'b0, den_i});
        assign r_c[i+1] = fits ? diff[W-1:0] : trial[W-1:0];
        assign q_c[i+1] = {q_c[i][W-2:0], fits};
    end

    assign rem_o = r_c[K];
    assign quo_o = q_c[K];
endmodule

// File: rtl/div_result_fixup.sv
`timescale 1ns/1ps
module div_result_fixup #(
    parameter int W = 32
) (
    input  logic [W-1:0] mag_q_i,
    input  logic [W-1:0] mag_r_i,
    input  logic         neg_q_i,
    input  logic         neg_r_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);
    always_comb begin
        quot_o = neg_q_i ? (~mag_q_i + 1'b1) : mag_q_i;
        rem_o  = neg_r_i ? (~mag_r_i + 1'b1) : mag_r_i;
    end
endmodule

// File: rtl/mmio_divider.sv
`timescale 1ns/1ps
module mmio_divider
    import div_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int BITS_PER_CYCLE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int STEPS = DATA_W / BITS_PER_CYCLE;
    localparam int CNT_W = $clog2(STEPS + 1);

    typedef struct packed {
        logic [DATA_W-1:0] num;
        logic [DATA_W-1:0] den;
        logic [DATA_W-1:0] quot;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] part_r;
        logic [DATA_W-1:0] part_q;
        logic [DATA_W-1:0] den_mag;
        logic [CNT_W-1:0]  left;
        logic              is_signed;
        logic              neg_q;
        logic              neg_r;
        logic              ready;
        logic              dirty;
    } state_t;

    state_t st_d, st_q;

    // bus decode
    logic wr_acc, rd_acc, num_alias, den_alias, wr_op, wr_res, rd_quot;
    always_comb begin
        wr_acc    = bus_valid & bus_write;
        rd_acc    = bus_valid & ~bus_write;
        num_alias = (bus_addr == A_UNUM) || (bus_addr == A_SNUM);
        den_alias = (bus_addr == A_UDEN) || (bus_addr == A_SDEN);
        wr_op     = wr_acc & (num_alias | den_alias);
        wr_res    = wr_acc & ((bus_addr == A_QUOT) || (bus_addr == A_REM));
        rd_quot   = rd_acc & (bus_addr == A_QUOT);
    end

    // operand values as they will be after this cycle's write
    logic [DATA_W-1:0] nxt_num, nxt_den;
    logic              nxt_signed;
    always_comb begin
        nxt_num    = (wr_op && num_alias) ? bus_wdata : st_q.num;
        nxt_den    = (wr_op && den_alias) ? bus_wdata : st_q.den;
        nxt_signed = (bus_addr == A_SNUM) || (bus_addr == A_SDEN);
    end

    logic [DATA_W-1:0] mag_num, mag_den;
    logic              prep_neg_q, prep_neg_r;

    div_operand_prep #(.W(DATA_W)) u_prep (
        .num_i     (nxt_num),
        .den_i     (nxt_den),
        .signed_i  (nxt_signed),
        .mag_num_o (mag_num),
        .mag_den_o (mag_den),
        .neg_q_o   (prep_neg_q),
        .neg_r_o   (prep_neg_r)
    );

    logic [DATA_W-1:0] step_r, step_q;

    div_radix_step #(.W(DATA_W), .K(BITS_PER_CYCLE)) u_step (
        .rem_i (st_q.part_r),
        .quo_i (st_q.part_q),
        .den_i (st_q.den_mag),
        .rem_o (step_r),
        .quo_o (step_q)
    );

    logic [DATA_W-1:0] fix_q, fix_r;

    div_result_fixup #(.W(DATA_W)) u_fix (
        .mag_q_i (step_q),
        .mag_r_i (step_r),
        .neg_q_i (st_q.neg_q),
        .neg_r_i (st_q.neg_r),
        .quot_o  (fix_q),
        .rem_o   (fix_r)
    );

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (wr_op) begin
            st_d.num       = nxt_num;
            st_d.den       = nxt_den;
            st_d.is_signed = nxt_signed;
            st_d.part_r    = '0;
            st_d.part_q    = mag_num;
            st_d.den_mag   = mag_den;
            st_d.neg_q     = prep_neg_q;
            st_d.neg_r     = prep_neg_r;
            st_d.left      = CNT_W'(STEPS);
            st_d.ready     = 1'b0;
            st_d.dirty     = 1'b1;
        end else if (wr_res) begin
            if (bus_addr == A_QUOT) begin
                st_d.quot = bus_wdata;
            end else begin
                st_d.rem  = bus_wdata;
            end
            st_d.left  = '0;
            st_d.ready = 1'b1;
            st_d.dirty = 1'b1;
        end else begin
            if (rd_quot) begin
                st_d.dirty = 1'b0;
            end
            if (!st_q.ready) begin
                st_d.part_r = step_r;
                st_d.part_q = step_q;
                st_d.left   = st_q.left - 1'b1;
                if (st_q.left == CNT_W'(1)) begin
                    st_d.ready = 1'b1;
                    st_d.quot  = fix_q;
                    st_d.rem   = fix_r;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ready <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_UNUM, A_SNUM: bus_rdata = st_q.num;
            A_UDEN, A_SDEN: bus_rdata = st_q.den;
            A_QUOT:         bus_rdata = st_q.quot;
            A_REM:          bus_rdata = st_q.rem;
            A_STAT: begin
                bus_rdata[STAT_READY_BIT] = st_q.ready;
                bus_rdata[STAT_DIRTY_BIT] = st_q.dirty;
            end
            default:        bus_rdata = '0;
        endcase
    end

    logic ready_q, dirty_q;
    assign ready_q = st_q.ready;
    assign dirty_q = st_q.dirty;
endmodule

// File: rtl/div_checker.sv
`timescale 1ns/1ps
module div_checker
    import div_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEPS  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_valid,
    input logic                  bus_write,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic                  ready,
    input logic                  dirty
);
    logic op_wr, res_wr, quot_rd, rem_rd, stat_rd;
    assign op_wr   = bus_valid && bus_write && (bus_addr <= A_SDEN);
    assign res_wr  = bus_valid && bus_write && (bus_addr == A_QUOT || bus_addr == A_REM);
    assign quot_rd = bus_valid && !bus_write && bus_addr == A_QUOT;
    assign rem_rd  = bus_valid && !bus_write && bus_addr == A_REM;
    assign stat_rd = bus_valid && !bus_write && bus_addr == A_STAT;

    logic run;
    int   cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cyc <= 0;
        end else if (op_wr) begin
            run <= 1'b1;
            cyc <= 0;
        end else if (res_wr) begin
            run <= 1'b0;
        end else if (run) begin
            if (cyc == STEPS) run <= 1'b0;
            else              cyc <= cyc + 1;
        end
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> (!ready && dirty));

    assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cyc < STEPS) |-> !ready);

    assert_done_on_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cyc == STEPS) |-> ready);

    assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> (ready && dirty));

    assert_quot_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        quot_rd |=> !dirty);

    assert_rem_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_rd && dirty) |=> dirty);

    assert_status_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> (bus_rdata[DATA_W-1:2] == '0));
endmodule

bind mmio_divider div_checker #(
    .DATA_W (DATA_W),
    .STEPS  (STEPS)
) u_div_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ready     (ready_q),
    .dirty     (dirty_q)
);

// File: tb/mmio_divider_tb_top.sv
`timescale 1ns/1ps
module mmio_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mmio_divider dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // behavioural reference state
    logic [31:0] m_num = 0, m_den = 0, m_quot = 0, m_rem = 0;
    bit          m_signed = 0;
    bit          m_dirty = 0;
    int          m_left = 0;

    task automatic compute_result();
        longint sn, sd, q, r;
        if (!m_signed) begin
            if (m_den == 0) begin
                m_quot = 32'hFFFF_FFFF;
                m_rem  = m_num;
            end else begin
                m_quot = m_num / m_den;
                m_rem  = m_num % m_den;
            end
        end else begin
            sn = longint'($signed(m_num));
            sd = longint'($signed(m_den));
            if (sd == 0) begin
                q = (sn < 0) ? 1 : -1;
                r = sn;
            end else begin
                q = sn / sd;
                r = sn % sd;
            end
            m_quot = q[31:0];
            m_rem  = r[31:0];
        end
    endtask

    function automatic logic [31:0] model_read(logic [2:0] a);
        case (a)
            3'd0, 3'd2: return m_num;
            3'd1, 3'd3: return m_den;
            3'd4:       return m_quot;
            3'd5:       return m_rem;
            3'd6:       return {30'd0, m_dirty, (m_left == 0)};
            default:    return 32'd0;
        endcase
    endfunction

    task automatic model_step(bit v, bit w, logic [2:0] a, logic [31:0] d);
        if (v && w && a <= 3'd3) begin
            if (a[0]) m_den = d; else m_num = d;
            m_signed = a[1];
            m_left   = 8;
            m_dirty  = 1;
        end else if (v && w && (a == 3'd4 || a == 3'd5)) begin
            if (a == 3'd4) m_quot = d; else m_rem = d;
            m_left  = 0;
            m_dirty = 1;
        end else begin
            if (v && !w && a == 3'd4) m_dirty = 0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) compute_result();
            end
        end
    endtask

    task automatic access(bit v, bit w, logic [2:0] a, logic [31:0] d, string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        if (v && !w && !((a == 3'd4 || a == 3'd5) && m_left != 0)) begin
            exp = model_read(a);
            checks++;
            if (bus_rdata !== exp) begin
                failures++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
            end
        end
        model_step(v, w, a, d);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
        access(1, 1, a, d, tag);
    endtask
    task automatic rd(logic [2:0] a, string tag);
        access(1, 0, a, 32'd0, tag);
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) access(0, 0, 3'd0, 32'd0, "idle");
    endtask

    // start a division, poll the status every cycle, then read results
    task automatic run_div(bit s, logic [31:0] n, logic [31:0] d, string tag);
        wr(s ? 3'd2 : 3'd0, n, tag);
        wr(s ? 3'd3 : 3'd1, d, tag);
        for (int i = 0; i < 9; i++) rd(3'd6, "R3 status poll");
        rd(3'd5, tag);
        rd(3'd6, "R8 dirty after remainder read");
        rd(3'd4, tag);
        rd(3'd6, "R8 dirty after quotient read");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 / R9 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), "R10 reset value");

        // R4 unsigned
        run_div(0, 32'd1000, 32'd7, "R4 unsigned 1000/7");
        run_div(0, 32'hFFFF_FFFF, 32'd3, "R4 unsigned max/3");
        run_div(0, 32'd5, 32'd9, "R4 unsigned small/large");

        // R5 signed sign rules
        run_div(1, -32'sd100, 32'sd7, "R5 signed neg/pos");
        run_div(1, 32'sd100, -32'sd7, "R5 signed pos/neg");
        run_div(1, -32'sd100, -32'sd7, "R5 signed neg/neg");
        run_div(1, 32'sd100, 32'sd7, "R5 signed pos/pos");
        run_div(1, 32'h8000_0000, 32'hFFFF_FFFF, "R5 signed min/-1");

        // R6 divide by zero
        run_div(0, 32'h1234_5678, 32'd0, "R6 unsigned by zero");
        run_div(1, 32'd77, 32'd0, "R6 signed pos by zero");
        run_div(1, -32'sd77, 32'd0, "R6 signed neg by zero");

        // R1 aliases: signed dividend write then unsigned divisor write -> unsigned
        wr(3'd2, 32'hFFFF_FFF0, "R1 alias dividend");
        rd(3'd0, "R1 alias readback unsigned addr");
        rd(3'd2, "R1 alias readback signed addr");
        wr(3'd1, 32'd16, "R1 alias divisor");
        rd(3'd3, "R1 divisor alias readback");
        idle(8);
        rd(3'd4, "R1 mode from last alias");
        rd(3'd5, "R1 mode from last alias");

        // R2 / R3 restart mid-calculation
        wr(3'd0, 32'd999, "R2 start");
        rd(3'd6, "R2 ready low dirty high");
        idle(3);
        wr(3'd1, 32'd10, "R3 restart");
        for (int i = 0; i < 9; i++) rd(3'd6, "R3 restart poll");
        rd(3'd4, "R3 restart result");

        // R7 result write aborts
        wr(3'd2, -32'sd5000, "R7 start");
        idle(2);
        wr(3'd4, 32'hCAFE_0001, "R7 quotient restore");
        rd(3'd6, "R7 ready and dirty set");
        idle(10);
        rd(3'd4, "R7 restored quotient kept");
        wr(3'd3, 32'd3, "R7 start again");
        idle(4);
        wr(3'd5, 32'h0000_BEEF, "R7 remainder restore");
        rd(3'd6, "R7 ready and dirty set");
        idle(10);
        rd(3'd5, "R7 restored remainder kept");
        rd(3'd6, "R8 remainder read keeps dirty");
        rd(3'd4, "R8 quotient read");
        rd(3'd6, "R8 dirty cleared");

        // R9 status and reserved writes ignored
        wr(3'd6, 32'hFFFF_FFFF, "R9 status write");
        rd(3'd6, "R9 status unchanged");
        wr(3'd7, 32'hFFFF_FFFF, "R9 reserved write");
        rd(3'd7, "R9 reserved reads zero");
        rd(3'd6, "R9 status unchanged");
        rd(3'd0, "R9 dividend unchanged");
        rd(3'd4, "R9 quotient unchanged");

        // mixed random operands
        for (int i = 0; i < 40; i++) begin
            logic [31:0] n, d;
            n = $urandom;
            d = (i % 5 == 0) ? ($urandom & 32'h0000_00FF) : $urandom >> (i % 31);
            run_div(i[0], n, d, i[0] ? "R5 random signed" : "R4 random unsigned");
        end

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule